// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block generates the fetch address for a short in-order pipeline. The pipeline's architecture guarantees that the instruction right after any branch always runs. A branch is resolved in the decode stage, the second stage. By the time a branch is resolved, the following word is already being fetched. That word is issued and marked as a slot instruction. The fetch address then moves to the target if the branch is taken, or continues in sequence if it is not. No bubble is ever inserted.

The block also captures the exception return state. An exception raised against the decode-stage instruction sends fetch to a fixed handler address and squashes the word fetched alongside it. It saves a return address and a flag that records whether the faulting instruction was a slot instruction. If it was a slot instruction, the saved address is that of its branch, so returning repeats the branch and the slot together. A return request reloads fetch from the saved address.

A branch in the slot of another branch is undefined.

Top module: `dslot_pc_seq`

## Requirements
- R1: With no taken branch, exception or return acting, `fetch_pc` advances by INSN_BYTES (default 4) on every clock edge.
- R2: The instruction after a valid decoded branch enters decode on the next edge with `dec_pc` equal to the branch address plus INSN_BYTES and `dec_in_slot` high, whether or not the branch is taken. In the cycle after that, `dec_in_slot` is low.
- R3: A valid taken branch in decode makes `fetch_pc` equal `br_target` one edge later.
- R4: A valid not-taken branch leaves fetch sequential, so `fetch_pc` is the branch address plus 2*INSN_BYTES one edge later.
- R5: An exception on a decode instruction that is not a slot instruction sets `epc` to that instruction's own address and clears `epc_in_slot`.
- R6: An exception on a slot instruction sets `epc` to the address of the preceding branch and sets `epc_in_slot`.
- R7: An exception makes `fetch_pc` equal EXC_VECTOR one edge later and clears `dec_valid` for that cycle. An exception request while `dec_valid` is low has no effect.
- R8: An exception and a taken branch in the same cycle: the exception wins, and the branch target is never fetched.
- R9: `eret_req` makes `fetch_pc` equal `epc` one edge later and clears `dec_valid` for that cycle.
- R10: Reset sets `fetch_pc` to RESET_PC and clears `dec_valid`, `dec_in_slot`, `epc` and `epc_in_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_valid | input | 1 | Decode instruction is a resolved branch |
| br_taken | input | 1 | Resolved branch is taken |
| br_target | input | ADDR_W | Branch target address |
| exc_req | input | 1 | Exception on the decode instruction |
| eret_req | input | 1 | Return from exception |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| dec_pc | output | ADDR_W | Address of the instruction in decode |
| dec_valid | output | 1 | Decode holds a live instruction |
| dec_in_slot | output | 1 | Decode instruction is a slot instruction |
| epc | output | ADDR_W | Saved exception return address |
| epc_in_slot | output | 1 | Saved fault was a slot instruction |

## Verification
Every result here comes from a single register stage. Redirects, the slot mark, the return address and its flag are all due one edge after the decode-stage request that causes them. The follow-on decode content is due one edge after that. The bench changes inputs 1 ns after a rising edge and holds them through the next edge. It reads the outputs 1 ns after that edge and derives every expected address from port values it captured before the stimulus. Return tests then step a further edge to confirm that the branch is fetched and decoded again.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
   typedef enum logic [1:0] {
      SEL_SEQ    = 2'd0,
      SEL_BRANCH = 2'd1,
      SEL_EXC    = 2'd2,
      SEL_ERET   = 2'd3
   } pc_sel_e;
endpackage

// File: rtl/dslot_redirect_sel.sv
module dslot_redirect_sel
   import dslot_pkg::*;
(
   input  logic    dec_valid,
   input  logic    br_valid,
   input  logic    br_taken,
   input  logic    exc_req,
   input  logic    eret_req,
   output pc_sel_e sel,
   output logic    exc_take,
   output logic    branch_seen,
   output logic    flush
);
   // An exception only counts when decode holds a live instruction.
   assign exc_take    = exc_req & dec_valid;
   assign branch_seen = br_valid & dec_valid;
   assign flush       = exc_take | eret_req;

   always_comb begin
      if (exc_take)                   sel = SEL_EXC;
      else if (eret_req)              sel = SEL_ERET;
      else if (branch_seen & br_taken) sel = SEL_BRANCH;
      else                            sel = SEL_SEQ;
   end
endmodule

// File: rtl/dslot_fetch_pc.sv
module dslot_fetch_pc
   import dslot_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] RESET_PC   = 'h1000,
   parameter logic [ADDR_W-1:0] EXC_VECTOR = 'h80
) (
   input  logic              clk,
   input  logic              rst,
   input  pc_sel_e           sel,
   input  logic [ADDR_W-1:0] br_target,
   input  logic [ADDR_W-1:0] epc,
   output logic [ADDR_W-1:0] pc_q
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] pc_d;

   always_comb begin
      unique case (sel)
         SEL_EXC:    pc_d = EXC_VECTOR;
         SEL_ERET:   pc_d = epc;
         SEL_BRANCH: pc_d = br_target;
         default:    pc_d = pc_q + STEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_d;
   end
endmodule

// File: rtl/dslot_decode_track.sv
module dslot_decode_track #(
   parameter int ADDR_W      = 32,
   parameter int INSN_BYTES  = 4,
   parameter bit STORE_BR_PC = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              flush,
   input  logic              branch_seen,
   output logic [ADDR_W-1:0] dec_pc,
   output logic              dec_valid,
   output logic              dec_in_slot,
   output logic [ADDR_W-1:0] branch_pc
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   always_ff @(posedge clk) begin
      if (rst) begin
         dec_pc      <= '0;
         dec_valid   <= 1'b0;
         dec_in_slot <= 1'b0;
      end else begin
         dec_pc      <= fetch_pc;
         dec_valid   <= ~flush;
         dec_in_slot <= ~flush & branch_seen;
      end
   end

   // Address of the branch that owns the current slot instruction.
   generate
      if (STORE_BR_PC) begin : g_stored
         logic [ADDR_W-1:0] br_pc_q;
         always_ff @(posedge clk) begin
            if (rst)              br_pc_q <= '0;
            else if (branch_seen) br_pc_q <= dec_pc;
         end
         assign branch_pc = br_pc_q;
      end else begin : g_derived
         assign branch_pc = dec_pc - STEP;
      end
   endgenerate
endmodule

// File: rtl/dslot_epc_unit.sv
module dslot_epc_unit #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exc_take,
   input  logic [ADDR_W-1:0] dec_pc,
   input  logic              dec_in_slot,
   input  logic [ADDR_W-1:0] branch_pc,
   output logic [ADDR_W-1:0] epc,
   output logic              epc_in_slot
);
   always_ff @(posedge clk) begin
      if (rst) begin
         epc         <= '0;
         epc_in_slot <= 1'b0;
      end else if (exc_take) begin
         epc         <= dec_in_slot ? branch_pc : dec_pc;
         epc_in_slot <= dec_in_slot;
      end
   end
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
   import dslot_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter int              INSN_BYTES  = 4,
   parameter logic [ADDR_W-1:0] RESET_PC    = 'h1000,
   parameter logic [ADDR_W-1:0] EXC_VECTOR  = 'h80,
   parameter bit              STORE_BR_PC = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              br_valid,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              exc_req,
   input  logic              eret_req,
   output logic [ADDR_W-1:0] fetch_pc,
   output logic [ADDR_W-1:0] dec_pc,
   output logic              dec_valid,
   output logic              dec_in_slot,
   output logic [ADDR_W-1:0] epc,
   output logic              epc_in_slot
);
   localparam int ALIGN_MASK = INSN_BYTES - 1;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("dslot_pc_seq: ADDR_W must be at least 8");
      end
      if (INSN_BYTES < 1 || (INSN_BYTES & ALIGN_MASK) != 0) begin : g_bad_step
         $error("dslot_pc_seq: INSN_BYTES must be a power of two");
      end
      if ((int'(RESET_PC) & ALIGN_MASK) != 0) begin : g_bad_reset
         $error("dslot_pc_seq: RESET_PC not aligned");
      end
   endgenerate

   pc_sel_e           sel;
   logic              exc_take;
   logic              branch_seen;
   logic              flush;
   logic [ADDR_W-1:0] branch_pc;

   dslot_redirect_sel u_sel (
      .dec_valid   (dec_valid),
      .br_valid    (br_valid),
      .br_taken    (br_taken),
      .exc_req     (exc_req),
      .eret_req    (eret_req),
      .sel         (sel),
      .exc_take    (exc_take),
      .branch_seen (branch_seen),
      .flush       (flush)
   );

   dslot_fetch_pc #(
      .ADDR_W     (ADDR_W),
      .INSN_BYTES (INSN_BYTES),
      .RESET_PC   (RESET_PC),
      .EXC_VECTOR (EXC_VECTOR)
   ) u_pc (
      .clk       (clk),
      .rst       (rst),
      .sel       (sel),
      .br_target (br_target),
      .epc       (epc),
      .pc_q      (fetch_pc)
   );

   dslot_decode_track #(
      .ADDR_W      (ADDR_W),
      .INSN_BYTES  (INSN_BYTES),
      .STORE_BR_PC (STORE_BR_PC)
   ) u_dec (
      .clk         (clk),
      .rst         (rst),
      .fetch_pc    (fetch_pc),
      .flush       (flush),
      .branch_seen (branch_seen),
      .dec_pc      (dec_pc),
      .dec_valid   (dec_valid),
      .dec_in_slot (dec_in_slot),
      .branch_pc   (branch_pc)
   );

   dslot_epc_unit #(
      .ADDR_W (ADDR_W)
   ) u_epc (
      .clk         (clk),
      .rst         (rst),
      .exc_take    (exc_take),
      .dec_pc      (dec_pc),
      .dec_in_slot (dec_in_slot),
      .branch_pc   (branch_pc),
      .epc         (epc),
      .epc_in_slot (epc_in_slot)
   );
endmodule

// File: rtl/dslot_pc_seq_chk.sv
module dslot_pc_seq_chk #(
   parameter int              ADDR_W     = 32,
   parameter int              INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] EXC_VECTOR = 'h80
) (
   input logic              clk,
   input logic              rst,
   input logic              br_valid,
   input logic              br_taken,
   input logic [ADDR_W-1:0] br_target,
   input logic              exc_req,
   input logic              eret_req,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic [ADDR_W-1:0] dec_pc,
   input logic              dec_valid,
   input logic              dec_in_slot,
   input logic [ADDR_W-1:0] epc,
   input logic              epc_in_slot
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   logic exc_live;
   assign exc_live = exc_req && dec_valid;

   a_r1_sequential: assert property (@(posedge clk) disable iff (rst)
      (!exc_live && !eret_req && !(dec_valid && br_valid && br_taken))
      |=> fetch_pc == $past(fetch_pc) + STEP);

   a_r2_slot_issued: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && br_valid && !exc_live && !eret_req)
      |=> dec_valid && dec_in_slot && dec_pc == $past(dec_pc) + STEP);

   a_r3_taken_redirect: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && br_valid && br_taken && !exc_live && !eret_req)
      |=> fetch_pc == $past(br_target));

   a_r5_plain_epc: assert property (@(posedge clk) disable iff (rst)
      (exc_live && !dec_in_slot)
      |=> !epc_in_slot && epc == $past(dec_pc));

   a_r6_slot_epc: assert property (@(posedge clk) disable iff (rst)
      (exc_live && dec_in_slot)
      |=> epc_in_slot && epc == $past(dec_pc) - STEP);

   a_r7_r8_exc_vector: assert property (@(posedge clk) disable iff (rst)
      exc_live |=> fetch_pc == EXC_VECTOR && !dec_valid);

   a_r9_eret_reload: assert property (@(posedge clk) disable iff (rst)
      (eret_req && !exc_live) |=> fetch_pc == $past(epc) && !dec_valid);

   a_r2_slot_implies_valid: assert property (@(posedge clk) disable iff (rst)
      dec_in_slot |-> dec_valid);
endmodule

bind dslot_pc_seq dslot_pc_seq_chk #(
   .ADDR_W     (ADDR_W),
   .INSN_BYTES (INSN_BYTES),
   .EXC_VECTOR (EXC_VECTOR)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .br_valid    (br_valid),
   .br_taken    (br_taken),
   .br_target   (br_target),
   .exc_req     (exc_req),
   .eret_req    (eret_req),
   .fetch_pc    (fetch_pc),
   .dec_pc      (dec_pc),
   .dec_valid   (dec_valid),
   .dec_in_slot (dec_in_slot),
   .epc         (epc),
   .epc_in_slot (epc_in_slot)
);

// File: tb/dslot_pc_seq_tb.sv
module dslot_pc_seq_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] RST_PC     = 32'h0000_1000;
   localparam logic [31:0] VEC        = 32'h0000_0080;
   localparam logic [31:0] STEP       = 32'd4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br_valid = 1'b0, br_taken = 1'b0, exc_req = 1'b0, eret_req = 1'b0;
   logic [31:0] br_target = '0;
   logic [31:0] fetch_pc, dec_pc, epc;
   logic        dec_valid, dec_in_slot, epc_in_slot;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dslot_pc_seq #(
      .ADDR_W (32), .INSN_BYTES (4), .RESET_PC (RST_PC), .EXC_VECTOR (VEC)
   ) dut_i (
      .clk (clk), .rst (rst), .br_valid (br_valid), .br_taken (br_taken),
      .br_target (br_target), .exc_req (exc_req), .eret_req (eret_req),
      .fetch_pc (fetch_pc), .dec_pc (dec_pc), .dec_valid (dec_valid),
      .dec_in_slot (dec_in_slot), .epc (epc), .epc_in_slot (epc_in_slot)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      br_valid = 1'b0; br_taken = 1'b0; exc_req = 1'b0; eret_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 fetch_pc", fetch_pc, RST_PC);
      chk("R10 dec_valid", 32'(dec_valid), 32'd0);
      chk("R10 dec_in_slot", 32'(dec_in_slot), 32'd0);
      chk("R10 epc", epc, 32'd0);
      chk("R10 epc_in_slot", 32'(epc_in_slot), 32'd0);
   endtask

   task automatic t_sequential();
      for (int i = 0; i < 3; i++) begin
         logic [31:0] prev = fetch_pc;
         step();
         chk("R1 fetch advance", fetch_pc, prev + STEP);
         chk("R1 decode follows", dec_pc, prev);
         chk("R1 decode live", 32'(dec_valid), 32'd1);
      end
   endtask

   task automatic t_taken(input logic [31:0] tgt);
      logic [31:0] a = dec_pc;
      br_valid = 1'b1; br_taken = 1'b1; br_target = tgt;
      step();
      idle_inputs();
      chk("R3 taken target", fetch_pc, tgt);
      chk("R2 slot addr", dec_pc, a + STEP);
      chk("R2 slot flag", 32'(dec_in_slot), 32'd1);
      step();
      chk("R2 target decoded", dec_pc, tgt);
      chk("R2 flag cleared", 32'(dec_in_slot), 32'd0);
      chk("R1 after target", fetch_pc, tgt + STEP);
   endtask

   task automatic t_not_taken();
      logic [31:0] a = dec_pc;
      br_valid = 1'b1; br_taken = 1'b0; br_target = 32'hDEAD_0000;
      step();
      idle_inputs();
      chk("R4 fall through", fetch_pc, a + 2*STEP);
      chk("R2 slot flag not taken", 32'(dec_in_slot), 32'd1);
      chk("R2 slot addr not taken", dec_pc, a + STEP);
      step();
   endtask

   task automatic t_exc_plain();
      logic [31:0] d = dec_pc;
      exc_req = 1'b1;
      step();
      idle_inputs();
      chk("R7 vector", fetch_pc, VEC);
      chk("R7 squash", 32'(dec_valid), 32'd0);
      chk("R5 own addr", epc, d);
      chk("R5 flag clear", 32'(epc_in_slot), 32'd0);
   endtask

   task automatic t_exc_ignored();
      logic [31:0] e = epc;
      logic [31:0] f = fetch_pc;
      exc_req = 1'b1;   // decode is squashed this cycle
      step();
      idle_inputs();
      chk("R7 ignored when idle", fetch_pc, f + STEP);
      chk("R7 epc untouched", epc, e);
   endtask

   task automatic t_eret_plain();
      logic [31:0] e = epc;
      eret_req = 1'b1;
      step();
      idle_inputs();
      chk("R9 reload", fetch_pc, e);
      chk("R9 squash", 32'(dec_valid), 32'd0);
      step();
      chk("R9 resumed decode", dec_pc, e);
   endtask

   task automatic t_exc_slot();
      logic [31:0] b = dec_pc;
      br_valid = 1'b1; br_taken = 1'b1; br_target = 32'h0000_3000;
      step();
      idle_inputs();
      exc_req = 1'b1;
      step();
      idle_inputs();
      chk("R6 branch addr", epc, b);
      chk("R6 flag set", 32'(epc_in_slot), 32'd1);
      chk("R7 vector from slot", fetch_pc, VEC);
      step();
      eret_req = 1'b1;
      step();
      idle_inputs();
      chk("R9 refetch branch", fetch_pc, b);
      step();
      chk("R9 branch redecoded", dec_pc, b);
      chk("R9 branch live", 32'(dec_valid), 32'd1);
   endtask

   task automatic t_exc_vs_branch();
      logic [31:0] d = dec_pc;
      br_valid = 1'b1; br_taken = 1'b1; br_target = 32'h0000_5000;
      exc_req = 1'b1;
      step();
      idle_inputs();
      chk("R8 exception wins", fetch_pc, VEC);
      chk("R8 epc", epc, d);
      step();
      chk("R8 target not fetched", fetch_pc, VEC + STEP);
      chk("R8 no slot mark", 32'(dec_in_slot), 32'd0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      t_reset();
      rst = 1'b0;
      step();
      chk("R1 first decode", dec_pc, RST_PC);
      t_sequential();
      t_taken(32'h0000_2000);
      t_not_taken();
      t_exc_plain();
      t_exc_ignored();
      t_eret_plain();
      step();
      t_exc_slot();
      step();
      t_exc_vs_branch();
      t_taken(32'h0000_0400);
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule